// File: doc/BRIEF.md
# Cache Parameter Tuning Controller

This controller runs a greedy search over the configuration space of a tunable cache. It tunes one parameter at a time: total size first, then line size, then associativity. For each trial configuration it asks an external energy unit for a figure and reads back a single comparator bit saying whether that figure beats the best so far. The energy arithmetic, the comparator and the cache are all outside the block. The controller only sequences the trials, decides which configuration to keep, and tells the external energy register when to latch a new best value.

A run begins with a baseline trial in which every parameter sits at its smallest value. After that, each parameter is stepped upward from its second value. A step is kept while each new trial improves on the best energy. The first trial that fails to improve ends the work on that parameter: the previous value is restored and the search moves to the next parameter. When associativity is finished, the controller reports completion and holds the winning configuration. It stays there until it is asked to tune again or its enable is withdrawn.

Top module: `cache_tune_ctrl`

## Requirements
- R1: After reset, and while `start` is low, the block is idle: `busy`, `done` and `calc_start` are 0, `adjust_param` reads 3 (none), and the three configuration indices read 0.
- R2: Whenever `start` is low at a clock edge, the block is idle after that edge (`busy` = 0, `done` = 0), whatever it was doing before.
- R3: Index i selects 2 KB << i for size, 16 B << i for line size and 1 << i ways for associativity. `adjust_param` codes are 0 = size, 1 = line size, 2 = associativity and 3 = none. The trials of a run are reported in this order: one baseline trial with all indices 0 (shown as size), then size trials, then line-size trials, then associativity trials.
- R4: Each trial is requested by a one-cycle `calc_start` pulse. The first pulse comes in the cycle after `start` is seen high in idle. Each later pulse comes in the cycle after the `calc_done` of the previous trial. No new pulse is issued while a result is outstanding.
- R5: When `calc_done` arrives with `energy_lower` = 1, the trial is kept and `best_load` is 1 in that same cycle. If the current parameter is below its top index, the next trial raises that parameter by one index.
- R6: When `calc_done` arrives with `energy_lower` = 0, the parameter returns to its last kept value. The next trial moves on to the following parameter at index 1; after associativity, the run ends instead.
- R7: The baseline trial of every run is kept, and `best_load` pulses for it, even when `energy_lower` is 0.
- R8: When a run ends, `done` = 1, `busy` = 0 and `adjust_param` = 3. The indices show the kept configuration and stay unchanged while `start` stays high and `tune_again` stays low.
- R9: While done, `tune_again` = 1 starts a fresh run from the baseline trial.
- R10: `busy` is 1 from the cycle of the first `calc_start` until the run ends or is aborted.
- R11: `calc_done` has no effect while the block is idle or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Enable; a run begins when high in idle, the block idles when low |
| tune_again | input | 1 | Restart request while done |
| calc_done | input | 1 | Energy result of the current trial is ready |
| energy_lower | input | 1 | Comparator: trial energy below best energy, valid with calc_done |
| cfg_size_idx | output | IW | Size index (2 KB << i) |
| cfg_line_idx | output | IW | Line size index (16 B << i) |
| cfg_assoc_idx | output | IW | Associativity index (1 << i ways) |
| calc_start | output | 1 | One-cycle request to evaluate the shown configuration |
| adjust_param | output | 2 | Parameter under adjustment (0 size, 1 line, 2 assoc, 3 none) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run complete, kept configuration shown |
| best_load | output | 1 | Latch the current trial energy as the new best |

## Verification
A wrong parameter or phase state in this block shows up at the `calc_start` that follows, as a wrong `adjust_param` code or wrong indices, so the error is visible one cycle after the faulty `calc_done`. A wrong kept-value register does not show while trials run. It appears when a parameter is rejected or the run ends, as a final configuration that differs from the greedy choice for the energy profile. A trial count that differs from the expected count exposes an early or late parameter change. A missing baseline load changes the final size index whenever the reference energy starts low.

// File: rtl/ctun_pkg.sv
package ctun_pkg;

    // number of candidate values per tunable parameter
    localparam int unsigned CT_NVALS = 3;
    // number of tunable parameters (size, line, associativity)
    localparam int unsigned CT_NPAR  = 3;

    typedef enum logic [1:0] {
        PAR_SIZE  = 2'd0,
        PAR_LINE  = 2'd1,
        PAR_ASSOC = 2'd2,
        PAR_NONE  = 2'd3
    } par_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // per-lane command bundle driven by the sequencer
    typedef struct packed {
        logic adv;
        logic accept;
        logic revert;
    } lane_cmd_t;

    function automatic par_e par_after(par_e p);
        case (p)
            PAR_SIZE: return PAR_LINE;
            PAR_LINE: return PAR_ASSOC;
            default:  return PAR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctun_lane.sv
module ctun_lane
    import ctun_pkg::*;
#(
    parameter int unsigned NVALS = CT_NVALS,
    parameter int unsigned IW    = $clog2(NVALS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            init,
    input  lane_cmd_t       cmd,
    output logic [IW-1:0]   trial_idx,
    output logic [IW-1:0]   best_idx,
    output logic            at_top
);

    localparam logic [IW-1:0] TOP_IDX = IW'(NVALS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_idx <= '0;
            best_idx  <= '0;
        end else if (init) begin
            trial_idx <= '0;
            best_idx  <= '0;
        end else begin
            if (cmd.accept) begin
                best_idx <= trial_idx;
            end
            if (cmd.adv) begin
                trial_idx <= trial_idx + IW'(1);
            end else if (cmd.revert) begin
                trial_idx <= best_idx;
            end
        end
    end

    assign at_top = (trial_idx == TOP_IDX);

endmodule

// File: rtl/ctun_seq.sv
module ctun_seq
    import ctun_pkg::*;
#(
    parameter int unsigned NPAR = CT_NPAR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tune_again,
    input  logic             calc_done,
    input  logic             energy_lower,
    input  logic [NPAR-1:0]  at_top,
    output logic             init,
    output lane_cmd_t        cmd [NPAR],
    output phase_e           phase,
    output par_e             par,
    output logic             best_load
);

    phase_e phase_n;
    par_e   par_n;
    logic   first_q, first_n;
    logic   improve;

    assign improve = first_q | energy_lower;

    always_comb begin
        phase_n   = phase;
        par_n     = par;
        first_n   = first_q;
        init      = 1'b0;
        best_load = 1'b0;
        for (int k = 0; k < int'(NPAR); k++) begin
            cmd[k] = '0;
        end

        if (!start) begin
            phase_n = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    init    = 1'b1;
                    par_n   = PAR_SIZE;
                    first_n = 1'b1;
                    phase_n = PH_REQ;
                end
                PH_REQ: begin
                    phase_n = PH_WAIT;
                end
                PH_WAIT: begin
                    if (calc_done) begin
                        first_n = 1'b0;
                        if (improve) begin
                            best_load = 1'b1;
                        end
                        for (int k = 0; k < int'(NPAR); k++) begin
                            if (int'(par) == k) begin
                                cmd[k].accept = improve;
                                cmd[k].adv    = improve & ~at_top[k];
                                cmd[k].revert = ~improve;
                            end
                        end
                        if (improve && !at_top[int'(par)]) begin
                            phase_n = PH_REQ;
                        end else if (par == PAR_ASSOC) begin
                            phase_n = PH_DONE;
                            par_n   = PAR_NONE;
                        end else begin
                            par_n   = par_after(par);
                            phase_n = PH_REQ;
                            for (int k = 0; k < int'(NPAR); k++) begin
                                if (int'(par) + 1 == k) begin
                                    cmd[k].adv = 1'b1;
                                end
                            end
                        end
                    end
                end
                PH_DONE: begin
                    if (tune_again) begin
                        init    = 1'b1;
                        par_n   = PAR_SIZE;
                        first_n = 1'b1;
                        phase_n = PH_REQ;
                    end
                end
                default: phase_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            par     <= PAR_NONE;
            first_q <= 1'b0;
        end else begin
            phase   <= phase_n;
            par     <= par_n;
            first_q <= first_n;
        end
    end

endmodule

// File: rtl/cache_tune_ctrl.sv
module cache_tune_ctrl
    import ctun_pkg::*;
#(
    parameter int unsigned NVALS = CT_NVALS,
    localparam int unsigned IW   = $clog2(NVALS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tune_again,
    input  logic          calc_done,
    input  logic          energy_lower,
    output logic [IW-1:0] cfg_size_idx,
    output logic [IW-1:0] cfg_line_idx,
    output logic [IW-1:0] cfg_assoc_idx,
    output logic          calc_start,
    output logic [1:0]    adjust_param,
    output logic          busy,
    output logic          done,
    output logic          best_load
);

    localparam int unsigned NPAR = CT_NPAR;

    logic            init;
    lane_cmd_t       cmd [NPAR];
    phase_e          phase;
    par_e            par;
    logic [NPAR-1:0] at_top;
    logic [IW-1:0]   trial_idx [NPAR];
    logic [IW-1:0]   best_idx  [NPAR];
    logic [IW-1:0]   shown_idx [NPAR];

    ctun_seq #(.NPAR(NPAR)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .tune_again   (tune_again),
        .calc_done    (calc_done),
        .energy_lower (energy_lower),
        .at_top       (at_top),
        .init         (init),
        .cmd          (cmd),
        .phase        (phase),
        .par          (par),
        .best_load    (best_load)
    );

    generate
        for (genvar g = 0; g < int'(NPAR); g++) begin : g_lane
            ctun_lane #(.NVALS(NVALS), .IW(IW)) u_lane (
                .clk       (clk),
                .rst       (rst),
                .init      (init),
                .cmd       (cmd[g]),
                .trial_idx (trial_idx[g]),
                .best_idx  (best_idx[g]),
                .at_top    (at_top[g])
            );
            assign shown_idx[g] = busy ? trial_idx[g] : best_idx[g];
        end
    endgenerate

    assign busy          = (phase == PH_REQ) || (phase == PH_WAIT);
    assign done          = (phase == PH_DONE);
    assign calc_start    = (phase == PH_REQ);
    assign adjust_param  = busy ? par : PAR_NONE;
    assign cfg_size_idx  = shown_idx[0];
    assign cfg_line_idx  = shown_idx[1];
    assign cfg_assoc_idx = shown_idx[2];

endmodule

// File: rtl/ctun_chk.sv
module ctun_chk #(
    parameter int unsigned NVALS = 3,
    parameter int unsigned IW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          tune_again,
    input logic          calc_done,
    input logic [IW-1:0] cfg_size_idx,
    input logic [IW-1:0] cfg_line_idx,
    input logic [IW-1:0] cfg_assoc_idx,
    input logic          calc_start,
    input logic [1:0]    adjust_param,
    input logic          busy,
    input logic          done,
    input logic          best_load
);

    // R4
    calc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        calc_start |=> !calc_start);

    // R4
    next_req_chk: assert property (@(posedge clk) disable iff (rst)
        (calc_done && busy && !calc_start && start) |=> (calc_start || done));

    // R10
    busy_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        calc_start |-> busy);

    // R8
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R2
    start_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!busy && !done));

    // R3
    adjust_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (adjust_param == 2'd3));

    // R8
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (done && start && !tune_again) |=>
            (done && $stable(cfg_size_idx) && $stable(cfg_line_idx) && $stable(cfg_assoc_idx)));

    // R5
    load_timing_chk: assert property (@(posedge clk) disable iff (rst)
        best_load |-> (calc_done && busy && !calc_start));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_size_idx) < int'(NVALS)) && (int'(cfg_line_idx) < int'(NVALS))
            && (int'(cfg_assoc_idx) < int'(NVALS)));

endmodule

bind cache_tune_ctrl ctun_chk #(.NVALS(NVALS), .IW(IW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .tune_again    (tune_again),
    .calc_done     (calc_done),
    .cfg_size_idx  (cfg_size_idx),
    .cfg_line_idx  (cfg_line_idx),
    .cfg_assoc_idx (cfg_assoc_idx),
    .calc_start    (calc_start),
    .adjust_param  (adjust_param),
    .busy          (busy),
    .done          (done),
    .best_load     (best_load)
);

// File: tb/cache_tune_ctrl_tb.sv
module cache_tune_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       tune_again = 1'b0;
    logic       calc_done = 1'b0;
    logic       energy_lower = 1'b0;
    logic [1:0] cfg_size_idx, cfg_line_idx, cfg_assoc_idx;
    logic       calc_start, busy, done, best_load;
    logic [1:0] adjust_param;

    int checks = 0;
    int errors = 0;
    int cs [3];
    int cl [3];
    int ca [3];
    int ebest;
    int n_req;
    int n_load;
    int par_log [16];

    always #5 clk = ~clk;

    cache_tune_ctrl u_dut (
        .clk(clk), .rst(rst), .start(start), .tune_again(tune_again),
        .calc_done(calc_done), .energy_lower(energy_lower),
        .cfg_size_idx(cfg_size_idx), .cfg_line_idx(cfg_line_idx),
        .cfg_assoc_idx(cfg_assoc_idx), .calc_start(calc_start),
        .adjust_param(adjust_param), .busy(busy), .done(done),
        .best_load(best_load)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // external energy unit: latency 2, separable cost model
    initial begin
        int cur;
        forever begin
            @(negedge clk);
            while (calc_start) begin
                n_req++;
                if (n_req <= 16) par_log[n_req-1] = int'(adjust_param);
                cur = cs[cfg_size_idx] + cl[cfg_line_idx] + ca[cfg_assoc_idx];
                @(negedge clk);
                @(negedge clk);
                calc_done = 1'b1;
                energy_lower = (cur < ebest);
                #1;
                if (best_load) begin
                    ebest = cur;
                    n_load++;
                end
                @(negedge clk);
                calc_done = 1'b0;
                energy_lower = 1'b0;
            end
        end
    end

    function automatic int pick(input int c0, input int c1, input int c2);
        if (c1 >= c0) return 0;
        if (c2 >= c1) return 1;
        return 2;
    endfunction

    function automatic int lane_trials(input int p);
        return (p == 2) ? 2 : p + 1;
    endfunction

    task automatic set_costs(input int s0, input int s1, input int s2,
                             input int l0, input int l1, input int l2,
                             input int a0, input int a1, input int a2);
        cs[0] = s0; cs[1] = s1; cs[2] = s2;
        cl[0] = l0; cl[1] = l1; cl[2] = l2;
        ca[0] = a0; ca[1] = a1; ca[2] = a2;
    endtask

    // runs one search and checks the result against the greedy model
    task automatic run_search(input string tag, input int e_init, input bit via_again);
        int ps, pl, pa, nexp, pos, waited;
        ps = pick(cs[0], cs[1], cs[2]);
        pl = pick(cl[0], cl[1], cl[2]);
        pa = pick(ca[0], ca[1], ca[2]);
        nexp = 1 + lane_trials(ps) + lane_trials(pl) + lane_trials(pa);
        ebest = e_init;
        n_req = 0;
        n_load = 0;
        @(negedge clk);
        if (via_again) tune_again = 1'b1;
        else start = 1'b1;
        @(negedge clk);
        tune_again = 1'b0;
        // R4 R10: first request one cycle after start/tune_again is seen
        chk(calc_start == 1'b1, "R4", {tag, " first calc_start"}, int'(calc_start), 1);
        chk(busy == 1'b1, "R10", {tag, " busy during run"}, int'(busy), 1);
        chk(adjust_param == 2'd0 && cfg_size_idx == 0 && cfg_line_idx == 0 && cfg_assoc_idx == 0,
            "R3", {tag, " baseline trial"}, int'({adjust_param, cfg_size_idx, cfg_line_idx, cfg_assoc_idx}), 0);
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1 && busy == 1'b0, "R8", {tag, " run completes"}, int'({done, busy}), 2);
        chk(adjust_param == 2'd3, "R8", {tag, " adjust none at end"}, int'(adjust_param), 3);
        chk(int'(cfg_size_idx) == ps, "R5", {tag, " final size idx"}, int'(cfg_size_idx), ps);
        chk(int'(cfg_line_idx) == pl, "R6", {tag, " final line idx"}, int'(cfg_line_idx), pl);
        chk(int'(cfg_assoc_idx) == pa, "R6", {tag, " final assoc idx"}, int'(cfg_assoc_idx), pa);
        chk(n_req == nexp, "R6", {tag, " trial count"}, n_req, nexp);
        // R3: parameter order of the requests
        pos = 0;
        chk(par_log[pos] == 0, "R3", {tag, " baseline code"}, par_log[pos], 0);
        pos++;
        for (int i = 0; i < lane_trials(ps); i++) begin
            chk(par_log[pos] == 0, "R3", {tag, " size code"}, par_log[pos], 0);
            pos++;
        end
        for (int i = 0; i < lane_trials(pl); i++) begin
            chk(par_log[pos] == 1, "R3", {tag, " line code"}, par_log[pos], 1);
            pos++;
        end
        for (int i = 0; i < lane_trials(pa); i++) begin
            chk(par_log[pos] == 2, "R3", {tag, " assoc code"}, par_log[pos], 2);
            pos++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1
        chk(busy == 0 && done == 0 && calc_start == 0, "R1", "idle flags", int'({busy, done, calc_start}), 0);
        chk(adjust_param == 2'd3, "R1", "idle adjust code", int'(adjust_param), 3);
        chk(cfg_size_idx == 0 && cfg_line_idx == 0 && cfg_assoc_idx == 0, "R1", "idle cfg",
            int'({cfg_size_idx, cfg_line_idx, cfg_assoc_idx}), 0);
    endtask

    task automatic t_hold();
        logic [5:0] snap;
        snap = {cfg_size_idx, cfg_line_idx, cfg_assoc_idx};
        repeat (20) @(negedge clk);
        // R8
        chk(done == 1'b1, "R8", "done held", int'(done), 1);
        chk({cfg_size_idx, cfg_line_idx, cfg_assoc_idx} == snap, "R8", "cfg held",
            int'({cfg_size_idx, cfg_line_idx, cfg_assoc_idx}), int'(snap));
        chk(n_req == 0 || calc_start == 0, "R8", "no request while held", int'(calc_start), 0);
    endtask

    task automatic t_abort();
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        // R2
        chk(done == 0 && busy == 0, "R2", "drop from done", int'({done, busy}), 0);
        set_costs(9, 5, 1, 4, 3, 1, 3, 2, 1);
        ebest = 1000;
        @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        // R2
        chk(busy == 0 && done == 0, "R2", "abort mid-run", int'({busy, done}), 0);
        chk(adjust_param == 2'd3, "R2", "abort adjust code", int'(adjust_param), 3);
        repeat (6) @(negedge clk);
        // R11: pending result lands while idle
        chk(busy == 0 && done == 0 && calc_start == 0, "R11", "late calc_done ignored",
            int'({busy, done, calc_start}), 0);
        calc_done = 1'b1;
        energy_lower = 1'b1;
        @(negedge clk);
        calc_done = 1'b0;
        energy_lower = 1'b0;
        @(negedge clk);
        chk(busy == 0 && calc_start == 0 && best_load == 0, "R11", "idle calc_done ignored",
            int'({busy, calc_start, best_load}), 0);
    endtask

    task automatic t_done_ignore();
        logic [5:0] snap;
        snap = {cfg_size_idx, cfg_line_idx, cfg_assoc_idx};
        @(negedge clk);
        calc_done = 1'b1;
        energy_lower = 1'b1;
        @(negedge clk);
        calc_done = 1'b0;
        energy_lower = 1'b0;
        @(negedge clk);
        // R11
        chk(done == 1'b1 && calc_start == 1'b0, "R11", "calc_done in done ignored",
            int'({done, calc_start}), 2);
        chk({cfg_size_idx, cfg_line_idx, cfg_assoc_idx} == snap, "R11", "cfg unchanged",
            int'({cfg_size_idx, cfg_line_idx, cfg_assoc_idx}), int'(snap));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_costs(0, 0, 0, 0, 0, 0, 0, 0, 0);
        t_reset();
        // mixed profile: size stops at 1, line climbs to top, assoc stays
        set_costs(9, 5, 7, 4, 3, 1, 2, 6, 1);
        run_search("R5 mixed", 1000, 1'b0);
        t_hold();
        t_done_ignore();
        // R9: restart with every cost rising, expect all smallest
        set_costs(1, 2, 3, 1, 2, 3, 1, 2, 3);
        run_search("R9 again rising", 1000, 1'b1);
        // every cost falling, expect all at top
        set_costs(9, 5, 1, 8, 4, 2, 7, 3, 0);
        run_search("R5 falling", 1000, 1'b1);
        // R7: reference starts at 0, so the baseline must be taken anyway
        set_costs(5, 3, 1, 2, 2, 2, 2, 2, 2);
        run_search("R7 baseline", 0, 1'b1);
        chk(n_load == 3, "R7", "best_load count", n_load, 3);
        t_abort();
        // restart from idle after abort
        set_costs(3, 4, 1, 6, 2, 3, 5, 5, 4);
        run_search("R1 after abort", 1000, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule